// File: doc/BRIEF.md
# Windowed Watchdog with Power-Up Phase

This block supervises a host processor. The host proves it is alive by pulling a trigger line from high to low. The block answers with an active-low reset pulse when the host triggers at the wrong time or not at all. Time is measured in ticks, which come from a periodic one-cycle enable. Each of the three durations is a tick count held on an input: the window length, the power-up length and the reset-pulse length.

After reset the block is in a power-up phase. In this phase any trigger is accepted. If no trigger arrives within the power-up length, the block gives a reset pulse and starts the power-up phase again. The first trigger starts windowed operation. In windowed operation, each period has a closed first half and an open second half. A trigger in the open half starts a new period. A trigger in the closed half gives a reset pulse. A period that runs out without a trigger also gives a reset pulse. A new period starts only when the pulse ends. A disable input stands in for the unconfigured case: while it is high, reset stays high and triggers are ignored.

All inputs are synchronous to `clk`. The trigger is a plain level input. There is no data stream, so every pin is a plain control or status signal. The inputs are sampled at each rising clock edge. A decision taken at an edge shows on `wd_rst_n` right after that edge.

Top module: `wwdog_top`

## Requirements
- R1: While `rst_n` is low, and after it is released, `wd_rst_n` is high and the block is in the power-up phase with its tick count at zero.
- R2: A trigger is an edge where `trig_in` is sampled low after being sampled high. A steady low or high level counts as nothing, and so does a rising transition.
- R3: In the power-up phase, the `pu_len`-th tick without a trigger starts a reset pulse. A trigger at any time in this phase starts windowed operation with a new period at tick count zero, and no pulse is given.
- R4: In windowed operation, a trigger when the count of ticks since the period start is at least floor(`win_len`/2) starts a new period, and `wd_rst_n` stays high.
- R5: In windowed operation, a trigger when the tick count is below floor(`win_len`/2) drives `wd_rst_n` low right after the edge that samples the trigger.
- R6: In windowed operation, the `win_len`-th tick without a trigger starts a reset pulse.
- R7: A reset pulse keeps `wd_rst_n` low until its `rst_len`-th tick. Triggers during the pulse are ignored. When the pulse ends, the block starts a new windowed period if it was in windowed operation, and a new power-up phase otherwise.
- R8: While `wd_disable` is high, `wd_rst_n` is high and triggers are ignored. After `wd_disable` is released, the block starts in the power-up phase.
- R9: When a trigger and a tick are sampled at the same edge, only the trigger takes effect and the tick is not counted. A length of zero acts as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base enable; each high cycle is one tick |
| trig_in | input | 1 | Host trigger level; a high-to-low change is a trigger |
| wd_disable | input | 1 | Holds the watchdog idle with its reset output high |
| win_len | input | CW | Window period in ticks |
| pu_len | input | CW | Power-up timeout in ticks |
| rst_len | input | CW | Reset pulse length in ticks |
| wd_rst_n | output | 1 | Active-low watchdog reset output |

## Verification
Some behaviour is checked by assertions on every cycle:
- the disable input holding the output high;
- a pulse holding while no tick arrives, whatever the trigger does;
- the immediate pulse after a closed-window trigger;
- the period restart after an open-window trigger;
- the move into windowed operation on the first trigger.

Other behaviour only shows up in the bench's scenarios against its reference model:
- exact pulse lengths;
- timeouts that repeat during power-up;
- the choice of phase after a pulse ends;
- the tie between a trigger and a tick in the same cycle;
- the treatment of odd window lengths.

// File: rtl/wwdog_pkg.sv
package wwdog_pkg;
  typedef enum logic [1:0] {
    PH_PWRUP = 2'd0,
    PH_RUN   = 2'd1,
    PH_PULSE = 2'd2
  } wd_phase_t;
endpackage

// File: rtl/wwdog_edge.sv
module wwdog_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= trig_i;
  end

  assign fall_o = prev_q & ~trig_i;
endmodule

// File: rtl/wwdog_seq.sv
module wwdog_seq
  import wwdog_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          fall_i,
  input  logic          dis_i,
  input  logic [CW-1:0] win_len_i,
  input  logic [CW-1:0] pu_len_i,
  input  logic [CW-1:0] rst_len_i,
  output wd_phase_t     phase_o
);
  localparam int EW = CW + 1;

  wd_phase_t     phase_q;
  logic [CW-1:0] cnt_q;
  logic          armed_q;
  logic [CW-1:0] half_len;
  logic [EW-1:0] cnt_next_ext;
  logic          pu_last, win_last, rst_last, in_closed;

  assign half_len     = win_len_i >> 1;
  assign cnt_next_ext = {1'b0, cnt_q} + EW'(1);
  assign pu_last      = cnt_next_ext >= {1'b0, pu_len_i};
  assign win_last     = cnt_next_ext >= {1'b0, win_len_i};
  assign rst_last     = cnt_next_ext >= {1'b0, rst_len_i};
  assign in_closed    = cnt_q < half_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_PWRUP;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (dis_i) begin
      phase_q <= PH_PWRUP;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      unique case (phase_q)
        PH_PWRUP: begin
          if (fall_i) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
            armed_q <= 1'b1;
          end else if (tick_i) begin
            if (pu_last) begin
              phase_q <= PH_PULSE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_next_ext[CW-1:0];
            end
          end
        end
        PH_RUN: begin
          if (fall_i) begin
            cnt_q   <= '0;
            phase_q <= in_closed ? PH_PULSE : PH_RUN;
          end else if (tick_i) begin
            if (win_last) begin
              phase_q <= PH_PULSE;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_next_ext[CW-1:0];
            end
          end
        end
        PH_PULSE: begin
          if (tick_i) begin
            if (rst_last) begin
              phase_q <= armed_q ? PH_RUN : PH_PWRUP;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_next_ext[CW-1:0];
            end
          end
        end
        default: begin
          phase_q <= PH_PWRUP;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase_o = phase_q;

  // pulse holds while no tick arrives; triggers have no effect
  p_pulse_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PULSE && !tick_i && !dis_i) |=> (phase_q == PH_PULSE));

  p_closed_trig_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && fall_i && !dis_i && cnt_q < half_len) |=> (phase_q == PH_PULSE));

  p_open_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RUN && fall_i && !dis_i && cnt_q >= half_len)
      |=> (phase_q == PH_RUN && cnt_q == '0));

  p_first_trig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PWRUP && fall_i && !dis_i) |=> (phase_q == PH_RUN && armed_q));
endmodule

// File: rtl/wwdog_top.sv
module wwdog_top
  import wwdog_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          trig_in,
  input  logic          wd_disable,
  input  logic [CW-1:0] win_len,
  input  logic [CW-1:0] pu_len,
  input  logic [CW-1:0] rst_len,
  output logic          wd_rst_n
);
  logic      fall;
  wd_phase_t phase;

  wwdog_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_in),
    .fall_o (fall)
  );

  wwdog_seq #(.CW(CW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick),
    .fall_i    (fall),
    .dis_i     (wd_disable),
    .win_len_i (win_len),
    .pu_len_i  (pu_len),
    .rst_len_i (rst_len),
    .phase_o   (phase)
  );

  assign wd_rst_n = (phase != PH_PULSE);

  p_disable_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wd_disable |=> wd_rst_n);

  p_reset_high_r1: assert property (@(posedge clk) !rst_n |-> wd_rst_n);
endmodule

// File: tb/tb_wwdog_top.sv
module tb_wwdog_top;
  localparam int CW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic          trig_in = 1'b1;
  logic          wd_disable = 1'b0;
  logic [CW-1:0] win_len = 12'd8;
  logic [CW-1:0] pu_len = 12'd6;
  logic [CW-1:0] rst_len = 12'd3;
  logic          wd_rst_n;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  // reference model: 0 power-up, 1 windowed, 2 pulse
  int m_ph = 0;
  int m_el = 0;
  bit m_arm = 1'b0;
  bit m_prev = 1'b1;

  always #2.5 clk = ~clk;

  wwdog_top #(.CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig_in(trig_in),
    .wd_disable(wd_disable), .win_len(win_len), .pu_len(pu_len),
    .rst_len(rst_len), .wd_rst_n(wd_rst_n)
  );

  function automatic int eff(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk) begin
    bit edge_seen;
    if (!rst_n) begin
      m_ph = 0; m_el = 0; m_arm = 0; m_prev = 1;
    end else begin
      edge_seen = m_prev && !trig_in;
      m_prev = trig_in;
      if (wd_disable) begin
        m_ph = 0; m_el = 0; m_arm = 0;
      end else if (m_ph == 2) begin
        if (tick) begin
          m_el++;
          if (m_el >= eff(rst_len)) begin m_ph = m_arm ? 1 : 0; m_el = 0; end
        end
      end else if (edge_seen) begin
        if (m_ph == 0) begin m_ph = 1; m_arm = 1; end
        else if (m_el < int'(win_len) / 2) m_ph = 2;
        m_el = 0;
      end else if (tick) begin
        m_el++;
        if (m_el >= eff(m_ph == 0 ? pu_len : win_len)) begin m_ph = 2; m_el = 0; end
      end
    end
  end

  task automatic check(input bit got, input bit exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: wd_rst_n=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) check(wd_rst_n, m_ph != 2, cur_req);
  end

  task automatic cyc(input bit t, input bit tr, input bit d);
    @(negedge clk); #1;
    tick = t; trig_in = tr; wd_disable = d;
  endtask

  task automatic idle(input int n, input bit t);
    for (int i = 0; i < n; i++) cyc(t, 1'b1, 1'b0);
  endtask

  task automatic pulse_trig(input bit t);
    cyc(t, 1'b0, 1'b0);
    cyc(t, 1'b1, 1'b0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, got timeout expected finish");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    check(wd_rst_n, 1'b1, "R1");
    #1 rst_n = 1'b1;
    cur_req = "R1";
    idle(3, 1'b0);
    check(wd_rst_n, 1'b1, "R1");

    // R3: power-up timeouts repeat
    cur_req = "R3";
    idle(30, 1'b1);
    // R3: arm during power-up
    pulse_trig(1'b0);
    // R4: open-window trigger after 5 ticks (half = 4)
    cur_req = "R4";
    idle(5, 1'b1);
    pulse_trig(1'b0);
    check(wd_rst_n, 1'b1, "R4");
    // R4 boundary: exactly half
    idle(4, 1'b1);
    pulse_trig(1'b0);
    check(wd_rst_n, 1'b1, "R4");
    // R5: closed-window trigger just below half
    cur_req = "R5";
    idle(3, 1'b1);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0);
    check(wd_rst_n, 1'b0, "R5");
    // R7: triggers during pulse ignored
    cur_req = "R7";
    pulse_trig(1'b0); pulse_trig(1'b0);
    check(wd_rst_n, 1'b0, "R7");
    idle(3, 1'b1);
    idle(2, 1'b0);
    check(wd_rst_n, 1'b1, "R7");
    // R6: expiry in windowed operation
    cur_req = "R6";
    idle(12, 1'b1);
    // R9: trigger with tick at the same edge
    cur_req = "R9";
    idle(6, 1'b1);
    pulse_trig(1'b1);
    idle(3, 1'b0);
    // R2: long low level and rising edges do nothing extra
    cur_req = "R2";
    idle(5, 1'b1);
    cyc(1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0);
    idle(6, 1'b1);
    // R8: disable with triggers
    cur_req = "R8";
    for (int i = 0; i < 20; i++) cyc(1'b1, i[0], 1'b1);
    check(wd_rst_n, 1'b1, "R8");
    idle(10, 1'b1);
    // R9: zero lengths act as one
    cyc(1'b0, 1'b1, 1'b1);
    win_len = 0; pu_len = 0; rst_len = 0;
    cur_req = "R9";
    idle(10, 1'b1);

    // random phase, lengths changed only while disabled
    cur_req = "R3/R4/R5/R6/R7";
    for (int i = 0; i < 20000; i++) begin
      if ($urandom_range(0, 499) == 0) begin
        cyc(1'b0, 1'b1, 1'b1);
        win_len = 12'($urandom_range(1, 20));
        pu_len  = 12'($urandom_range(1, 20));
        rst_len = 12'($urandom_range(1, 6));
        cyc(1'b0, 1'b1, 1'b1);
      end else begin
        cyc($urandom_range(0, 2) == 0,
            ($urandom_range(0, 5) == 0) ? ~trig_in : trig_in,
            1'b0);
      end
    end
    idle(2, 1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule